// File: doc/BRIEF.md
# Tagged Multi-Channel Debug Word FIFO

This peripheral moves 32-bit words between a processor and an external debug probe over sixteen logical channels. On the processor side a simple register bus reaches a configuration register, a status register, a receive data register and one transmit register per channel. A bus write to the transmit register of channel n stores the word and the tag n in a transmit queue. The probe drains that queue through a valid/ready output port and sees each word next to its channel tag. In the other direction the probe fills a receive queue through a valid/ready input port with tagged words. Software learns the tag of the oldest word from the status register, then reads the word and so removes it from the queue.

Each queue is managed by a three-state occupancy machine: EMPTY, PART and FULL. Its transitions are FILL (EMPTY to PART on an accepted push), TOP (PART to FULL when a push without a pop lands on the last free slot), DRAIN (PART to EMPTY when a pop without a push removes the last word) and FREE (FULL to PART on an accepted pop). Every other case holds the state. A level interrupt is the OR of two conditions, one per direction. Each condition has a two-bit mode field. The interrupt is recomputed every cycle from the current occupancies.

Top module: `dbg_chan_fifo`

## Requirements
- R1: After reset both queues are empty and both interrupt modes are 0. The interrupt output is low, `tx_out_valid` is low, `rx_in_ready` is high, the status register reads 0x0000000A and the configuration register reads 0x00000808 (depth 8 in each direction).
- R2: The configuration register is at offset 0x08. Bits 19:18 are the transmit interrupt mode and bits 17:16 are the receive interrupt mode, and both are writable. Bits 15:8 read the transmit depth and bits 7:0 read the receive depth. A write changes only bits 19:16, and all other bits read zero.
- R3: A bus write to offset 0x20 + 8·n, for n from 0 to 15, enqueues the write data tagged with channel n. The probe port presents the words in write order, with `tx_out_chan` equal to n, and removes one word per cycle in which valid and ready are both high.
- R4: A write to any transmit register while the transmit queue holds its depth in words is dropped. The occupancy stays at the depth and the stored words are unchanged.
- R5: The status register is at offset 0x10. Bits 31:24 hold the transmit occupancy and bits 23:16 the receive occupancy. Bits 7:4 hold the channel of the oldest received word, or 0 when the receive queue is empty. Bit 3 is receive empty, bit 2 receive full, bit 1 transmit empty and bit 0 transmit full. Writes to it are ignored.
- R6: `rx_in_ready` is high exactly when the receive queue is not full, and a word with its channel tag is stored when valid and ready are both high. A bus read of offset 0x18 returns the oldest received word and removes it.
- R7: A read of offset 0x18 while the receive queue is empty returns zero and leaves the status unchanged.
- R8: Transmit interrupt modes are 0 off, 1 queue empty, 2 queue not full, and 3 occupancy at most one quarter of the depth.
- R9: Receive interrupt modes are 0 off, 1 queue full, 2 queue not empty, and 3 occupancy at least three quarters of the depth.
- R10: `irq` is the OR of the two conditions. It follows an occupancy change in the same cycle the new occupancy is visible in status, and it is low while both modes are 0.
- R11: Bus accesses to unmapped offsets (0x00, 0x04, offsets at or above 0xA0, and any transmit offset that is not a multiple of 8) read zero and change nothing. Writes to offset 0x18 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| tx_out_valid | output | 1 | Transmit queue has a word for the probe |
| tx_out_ready | input | 1 | Probe takes the word |
| tx_out_data | output | 32 | Oldest transmit word |
| tx_out_chan | output | 4 | Channel tag of the oldest transmit word |
| rx_in_valid | input | 1 | Probe offers a word |
| rx_in_ready | output | 1 | Receive queue can take a word |
| rx_in_data | input | 32 | Offered word |
| rx_in_chan | input | 4 | Channel tag of the offered word |
| irq | output | 1 | Level interrupt |

## Verification
On every cycle the assertions check the following: occupancy bounds, that a push to a full transmit queue leaves its occupancy at the depth, and that a read of an empty receive queue leaves it empty. They also check that the probe handshake signals track occupancy and that the interrupt output agrees with the disabled, empty and full modes. Only the bench scenarios can show word ordering, channel tagging across several channels, the exact bit layout of the status and configuration registers, and the quarter-depth threshold edges. The same holds for unmapped-offset behaviour, all of which depend on the values of whole sequences rather than on single-cycle relations.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
    localparam int WORD_W  = 32;
    localparam int NCH     = 16;
    localparam int CH_W    = $clog2(NCH);

    localparam int OFS_CFG = 8'h08;
    localparam int OFS_STS = 8'h10;
    localparam int OFS_RX  = 8'h18;
    localparam int OFS_TX0 = 8'h20;

    typedef enum logic [1:0] {
        TXI_OFF       = 2'd0,
        TXI_EMPTY     = 2'd1,
        TXI_NOTFULL   = 2'd2,
        TXI_NEAREMPTY = 2'd3
    } tx_irq_mode_e;

    typedef enum logic [1:0] {
        RXI_OFF       = 2'd0,
        RXI_FULL      = 2'd1,
        RXI_NOTEMPTY  = 2'd2,
        RXI_NEARFULL  = 2'd3
    } rx_irq_mode_e;

    typedef enum logic [1:0] {
        FS_EMPTY = 2'd0,
        FS_PART  = 2'd1,
        FS_FULL  = 2'd2
    } fifo_state_e;
endpackage

// File: rtl/dcf_fifo.sv
module dcf_fifo
    import dcf_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DW    = 32,
    parameter int TW    = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [DW-1:0]              push_data,
    input  logic [TW-1:0]              push_tag,
    input  logic                       pop,
    output logic [DW-1:0]              head_data,
    output logic [TW-1:0]              head_tag,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       empty,
    output logic                       full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DW-1:0] data_mem [DEPTH];
    logic [TW-1:0] tag_mem  [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt_q;
    fifo_state_e   state_q, state_d;
    logic          push_ok, pop_ok;

    assign push_ok = push && (state_q != FS_FULL);
    assign pop_ok  = pop  && (state_q != FS_EMPTY);

    // next-state logic: FILL, TOP, DRAIN, FREE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_EMPTY: if (push_ok) state_d = FS_PART;
            FS_PART: begin
                if (push_ok && !pop_ok && cnt_q == CW'(DEPTH - 1))
                    state_d = FS_FULL;
                else if (pop_ok && !push_ok && cnt_q == CW'(1))
                    state_d = FS_EMPTY;
            end
            FS_FULL:  if (pop_ok) state_d = FS_PART;
            default:  state_d = FS_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FS_EMPTY;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        empty     = (state_q == FS_EMPTY);
        full      = (state_q == FS_FULL);
        count     = cnt_q;
        head_data = data_mem[rd_ptr];
        head_tag  = tag_mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + AW'(1);
            cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            data_mem[wr_ptr] <= push_data;
            tag_mem[wr_ptr]  <= push_tag;
        end
    end
endmodule

// File: rtl/dcf_irq_eval.sv
module dcf_irq_eval
    import dcf_pkg::*;
#(
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8
) (
    input  tx_irq_mode_e                  tx_mode,
    input  rx_irq_mode_e                  rx_mode,
    input  logic [$clog2(TX_DEPTH+1)-1:0] tx_cnt,
    input  logic [$clog2(RX_DEPTH+1)-1:0] rx_cnt,
    output logic                          irq
);
    localparam int TCW = $clog2(TX_DEPTH+1);
    localparam int RCW = $clog2(RX_DEPTH+1);
    // 4*cnt <= depth  <=>  cnt <= floor(depth/4)
    localparam int TX_NE = TX_DEPTH / 4;
    // 4*cnt >= 3*depth  <=>  cnt >= ceil(3*depth/4)
    localparam int RX_NF = (3 * RX_DEPTH + 3) / 4;

    logic tx_hit, rx_hit;

    always_comb begin
        unique case (tx_mode)
            TXI_OFF:       tx_hit = 1'b0;
            TXI_EMPTY:     tx_hit = (tx_cnt == '0);
            TXI_NOTFULL:   tx_hit = (tx_cnt != TCW'(TX_DEPTH));
            TXI_NEAREMPTY: tx_hit = (tx_cnt <= TCW'(TX_NE));
            default:       tx_hit = 1'b0;
        endcase
        unique case (rx_mode)
            RXI_OFF:       rx_hit = 1'b0;
            RXI_FULL:      rx_hit = (rx_cnt == RCW'(RX_DEPTH));
            RXI_NOTEMPTY:  rx_hit = (rx_cnt != '0);
            RXI_NEARFULL:  rx_hit = (rx_cnt >= RCW'(RX_NF));
            default:       rx_hit = 1'b0;
        endcase
        irq = tx_hit | rx_hit;
    end
endmodule

// File: rtl/dbg_chan_fifo.sv
module dbg_chan_fifo
    import dcf_pkg::*;
#(
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8,
    parameter int BUS_AW   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              tx_out_valid,
    input  logic              tx_out_ready,
    output logic [WORD_W-1:0] tx_out_data,
    output logic [CH_W-1:0]   tx_out_chan,
    input  logic              rx_in_valid,
    output logic              rx_in_ready,
    input  logic [WORD_W-1:0] rx_in_data,
    input  logic [CH_W-1:0]   rx_in_chan,
    output logic              irq
);
    localparam int TCW   = $clog2(TX_DEPTH+1);
    localparam int RCW   = $clog2(RX_DEPTH+1);
    localparam int SW    = BUS_AW - 3;
    localparam logic [SW-1:0] SLOT0    = SW'(OFS_TX0 / 8);
    localparam logic [SW-1:0] SLOT_END = SW'(OFS_TX0 / 8 + NCH);

    tx_irq_mode_e    tx_mode;
    rx_irq_mode_e    rx_mode;
    logic [TCW-1:0]  tx_cnt;
    logic [RCW-1:0]  rx_cnt;
    logic            tx_empty, tx_full, rx_empty, rx_full;
    logic [WORD_W-1:0] rx_head_data;
    logic [CH_W-1:0] rx_head_tag;
    logic [SW-1:0]   slot;
    logic            tx_slot_hit, wr_tx, wr_cfg, rd_rx, tx_pop, rx_push;
    logic [CH_W-1:0] wr_chan;

    assign slot        = bus_addr[BUS_AW-1:3];
    assign tx_slot_hit = (bus_addr[2:0] == 3'b000) && (slot >= SLOT0) && (slot < SLOT_END);
    assign wr_chan     = CH_W'(slot - SLOT0);
    assign wr_tx       = bus_sel && bus_we && tx_slot_hit;
    assign wr_cfg      = bus_sel && bus_we && (bus_addr == BUS_AW'(OFS_CFG));
    assign rd_rx       = bus_sel && !bus_we && (bus_addr == BUS_AW'(OFS_RX));
    assign tx_pop      = tx_out_valid && tx_out_ready;
    assign rx_push     = rx_in_valid && rx_in_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_mode <= TXI_OFF;
            rx_mode <= RXI_OFF;
        end else if (wr_cfg) begin
            tx_mode <= tx_irq_mode_e'(bus_wdata[19:18]);
            rx_mode <= rx_irq_mode_e'(bus_wdata[17:16]);
        end
    end

    dcf_fifo #(.DEPTH(TX_DEPTH), .DW(WORD_W), .TW(CH_W)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(wr_tx), .push_data(bus_wdata), .push_tag(wr_chan),
        .pop(tx_pop),
        .head_data(tx_out_data), .head_tag(tx_out_chan),
        .count(tx_cnt), .empty(tx_empty), .full(tx_full)
    );

    dcf_fifo #(.DEPTH(RX_DEPTH), .DW(WORD_W), .TW(CH_W)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .push_data(rx_in_data), .push_tag(rx_in_chan),
        .pop(rd_rx),
        .head_data(rx_head_data), .head_tag(rx_head_tag),
        .count(rx_cnt), .empty(rx_empty), .full(rx_full)
    );

    dcf_irq_eval #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_irq (
        .tx_mode(tx_mode), .rx_mode(rx_mode),
        .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .irq(irq)
    );

    assign tx_out_valid = !tx_empty;
    assign rx_in_ready  = !rx_full;

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            if (bus_addr == BUS_AW'(OFS_CFG))
                bus_rdata = {12'h000, tx_mode, rx_mode, 8'(TX_DEPTH), 8'(RX_DEPTH)};
            else if (bus_addr == BUS_AW'(OFS_STS))
                bus_rdata = {8'(tx_cnt), 8'(rx_cnt), 8'h00,
                             rx_empty ? '0 : rx_head_tag,
                             rx_empty, rx_full, tx_empty, tx_full};
            else if (bus_addr == BUS_AW'(OFS_RX))
                bus_rdata = rx_empty ? '0 : rx_head_data;
        end
    end
endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [$clog2(TX_DEPTH+1)-1:0] tx_cnt,
    input logic [$clog2(RX_DEPTH+1)-1:0] rx_cnt,
    input logic                          wr_tx,
    input logic                          rd_rx,
    input logic                          tx_pop,
    input logic                          rx_in_valid,
    input logic                          tx_out_valid,
    input logic                          rx_in_ready,
    input logic [1:0]                    tx_mode,
    input logic [1:0]                    rx_mode,
    input logic                          irq
);
    localparam int TCW = $clog2(TX_DEPTH+1);
    localparam int RCW = $clog2(RX_DEPTH+1);

    assert_tx_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cnt <= TCW'(TX_DEPTH));

    assert_rx_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= RCW'(RX_DEPTH));

    assert_tx_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt == TCW'(TX_DEPTH) && wr_tx && !tx_pop) |=> (tx_cnt == TCW'(TX_DEPTH)));

    assert_rx_empty_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt == '0 && rd_rx && !rx_in_valid) |=> (rx_cnt == '0));

    assert_rx_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_in_ready == (rx_cnt != RCW'(RX_DEPTH)));

    assert_tx_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_out_valid == (tx_cnt != '0));

    assert_irq_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_mode == 2'd0 && rx_mode == 2'd0) |-> !irq);

    assert_tx_empty_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_mode == 2'd1 && tx_cnt == '0) |-> irq);

    assert_rx_full_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_mode == 2'd1 && rx_cnt == RCW'(RX_DEPTH)) |-> irq);
endmodule

bind dbg_chan_fifo dcf_checker #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
    .wr_tx(wr_tx), .rd_rx(rd_rx), .tx_pop(tx_pop), .rx_in_valid(rx_in_valid),
    .tx_out_valid(tx_out_valid), .rx_in_ready(rx_in_ready),
    .tx_mode(tx_mode), .rx_mode(rx_mode), .irq(irq)
);

// File: tb/tb_dbg_chan_fifo.sv
module tb_dbg_chan_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        tx_out_valid, tx_out_ready = 1'b0;
    logic [31:0] tx_out_data;
    logic [3:0]  tx_out_chan;
    logic        rx_in_valid = 1'b0, rx_in_ready;
    logic [31:0] rx_in_data = '0;
    logic [3:0]  rx_in_chan = '0;
    logic        irq;

    int total = 0;
    int failed = 0;

    always #4 clk = ~clk;

    dbg_chan_fifo dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready),
        .tx_out_data(tx_out_data), .tx_out_chan(tx_out_chan),
        .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready),
        .rx_in_data(rx_in_data), .rx_in_chan(rx_in_chan), .irq(irq)
    );

    // {tx mode[15:14], rx mode[13:12], tx words[11:8], rx words[7:4], 3'b0, irq}
    localparam logic [15:0] VEC [15] = '{
        {2'd0, 2'd0, 4'd3, 4'd3, 4'd0},
        {2'd1, 2'd0, 4'd0, 4'd0, 4'd1},
        {2'd1, 2'd0, 4'd1, 4'd0, 4'd0},
        {2'd2, 2'd0, 4'd7, 4'd0, 4'd1},
        {2'd2, 2'd0, 4'd8, 4'd0, 4'd0},
        {2'd3, 2'd0, 4'd2, 4'd0, 4'd1},
        {2'd3, 2'd0, 4'd3, 4'd0, 4'd0},
        {2'd0, 2'd1, 4'd0, 4'd8, 4'd1},
        {2'd0, 2'd1, 4'd0, 4'd7, 4'd0},
        {2'd0, 2'd2, 4'd0, 4'd1, 4'd1},
        {2'd0, 2'd2, 4'd0, 4'd0, 4'd0},
        {2'd0, 2'd3, 4'd0, 4'd6, 4'd1},
        {2'd0, 2'd3, 4'd0, 4'd5, 4'd0},
        {2'd3, 2'd3, 4'd5, 4'd6, 4'd1},
        {2'd1, 2'd2, 4'd0, 4'd0, 4'd1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic probe_push(input logic [31:0] d, input logic [3:0] c);
        @(negedge clk);
        rx_in_valid = 1'b1; rx_in_data = d; rx_in_chan = c;
        @(negedge clk);
        rx_in_valid = 1'b0;
    endtask

    task automatic probe_pop(input string req, input logic [31:0] d, input logic [3:0] c);
        @(negedge clk);
        #1;
        check(req, {31'd0, tx_out_valid}, 32'd1);
        check(req, tx_out_data, d);
        check(req, {28'd0, tx_out_chan}, {28'd0, c});
        tx_out_ready = 1'b1;
        @(negedge clk);
        tx_out_ready = 1'b0;
    endtask

    function automatic logic [31:0] exp_status(int ntx, int nrx, logic [3:0] head);
        return {8'(ntx), 8'(nrx), 8'h00, (nrx == 0) ? 4'h0 : head,
                nrx == 0, nrx == 8, ntx == 0, ntx == 8};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        failed++;
        total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        do_reset();

        // R1 reset state
        #1;
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 tx_out_valid", {31'd0, tx_out_valid}, 32'd0);
        check("R1 rx_in_ready", {31'd0, rx_in_ready}, 32'd1);
        bus_read(8'h10, rd); check("R1 status", rd, 32'h0000_000A);
        bus_read(8'h08, rd); check("R1 cfg", rd, 32'h0000_0808);

        // R8 R9 R10: threshold table walk
        for (int v = 0; v < 15; v++) begin
            int ntx, nrx;
            ntx = int'(VEC[v][11:8]);
            nrx = int'(VEC[v][7:4]);
            do_reset();
            for (int k = 0; k < ntx; k++) bus_write(8'h20 + 8'(k % 16) * 8'd8, 32'h100 + k);
            for (int k = 0; k < nrx; k++) probe_push(32'h200 + k, 4'((k + 5) % 16));
            bus_write(8'h08, {12'd0, VEC[v][15:14], VEC[v][13:12], 16'd0});
            #1;
            check($sformatf("R8/R9/R10 irq vector %0d", v), {31'd0, irq}, {31'd0, VEC[v][0]});
            bus_read(8'h10, rd);
            check($sformatf("R5 status vector %0d", v), rd, exp_status(ntx, nrx, 4'd5));
        end

        // R2 read-only fields
        do_reset();
        bus_write(8'h08, 32'hFFFF_FFFF);
        bus_read(8'h08, rd); check("R2 cfg write mask", rd, 32'h000F_0808);
        bus_write(8'h08, 32'h0000_0000);
        bus_read(8'h08, rd); check("R2 cfg cleared", rd, 32'h0000_0808);

        // R3 channel tagging and order
        bus_write(8'h38, 32'h1111_1111);
        bus_write(8'h98, 32'h2222_2222);
        bus_write(8'h20, 32'h3333_3333);
        probe_pop("R3 first", 32'h1111_1111, 4'd3);
        probe_pop("R3 second", 32'h2222_2222, 4'd15);
        probe_pop("R3 third", 32'h3333_3333, 4'd0);
        #1 check("R3 drained", {31'd0, tx_out_valid}, 32'd0);

        // R4 overflow drop
        do_reset();
        for (int k = 0; k < 9; k++) bus_write(8'h28, 32'h500 + k);
        bus_read(8'h10, rd); check("R4 full status", rd, 32'h0800_0009);
        for (int k = 0; k < 8; k++) probe_pop("R4 kept word", 32'h500 + k, 4'd1);
        #1 check("R4 ninth dropped", {31'd0, tx_out_valid}, 32'd0);

        // R5 R6 head channel and dequeue
        do_reset();
        probe_push(32'hAAAA_0001, 4'd7);
        probe_push(32'hBBBB_0002, 4'd2);
        bus_read(8'h10, rd); check("R5 head chan 7", rd, 32'h0002_0072);
        bus_read(8'h18, rd); check("R6 first read", rd, 32'hAAAA_0001);
        bus_read(8'h10, rd); check("R5 head chan 2", rd, 32'h0001_0022);
        bus_read(8'h18, rd); check("R6 second read", rd, 32'hBBBB_0002);
        // R7 empty read
        bus_read(8'h18, rd); check("R7 empty read data", rd, 32'h0);
        bus_read(8'h10, rd); check("R7 status unchanged", rd, 32'h0000_000A);

        // R6 ready drops when full
        for (int k = 0; k < 8; k++) probe_push(32'h700 + k, 4'((k + 3) % 16));
        #1 check("R6 ready low when full", {31'd0, rx_in_ready}, 32'd0);
        probe_push(32'hDEAD_BEEF, 4'd9);
        bus_read(8'h10, rd); check("R6 full status", rd, 32'h0008_0036);

        // R11 unmapped and read-only offsets
        do_reset();
        bus_write(8'hA0, 32'h1234_5678);
        bus_write(8'h00, 32'hFFFF_FFFF);
        bus_write(8'h24, 32'h1234_5678);
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_write(8'h18, 32'hFFFF_FFFF);
        bus_read(8'h10, rd); check("R11 nothing queued", rd, 32'h0000_000A);
        bus_read(8'h00, rd); check("R11 read 0x00", rd, 32'h0);
        bus_read(8'h04, rd); check("R11 read 0x04", rd, 32'h0);
        bus_read(8'h20, rd); check("R11 read tx reg", rd, 32'h0);
        bus_read(8'h08, rd); check("R11 cfg untouched", rd, 32'h0000_0808);

        // R10 dynamic re-evaluation
        bus_write(8'h08, 32'h0002_0000);
        #1 check("R10 idle low", {31'd0, irq}, 32'd0);
        probe_push(32'h0000_0042, 4'd4);
        #1 check("R10 rises with push", {31'd0, irq}, 32'd1);
        bus_read(8'h18, rd); check("R6 read back", rd, 32'h0000_0042);
        #1 check("R10 falls with read", {31'd0, irq}, 32'd0);
        bus_write(8'h08, 32'h000C_0000);
        #1 check("R8 near empty at zero", {31'd0, irq}, 32'd1);

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule